// File: doc/BRIEF.md
# Custom Function Dispatcher

This block sits on the processor side of a set of attached custom function units. It accepts decoded instructions from the core. Each instruction that uses one of the two custom major opcodes is sent as a request to one attached unit. A software-written selector register, not the opcode bits, decides which unit receives the request and which isolated state context inside that unit the request names. Any selected unit may therefore use the whole custom opcode space.

For each request, the dispatcher builds a payload from the context index, a function code and the two source operands. It routes the payload to the selected unit over a valid/ready channel. It then takes that unit's response over a second valid/ready channel. The response value is presented to the core as the destination-register result. The response code is kept in a status register once the core accepts the result. Combinational, fixed-latency and variable-latency units all fit, because every stage waits on its handshake. Only one transaction is outstanding at a time.

Top module: `cfu_dispatch`

## Requirements
- R1: After reset, `sel_rdata` is 0, `cf_status` is 0, no `u_req_valid` or `u_rsp_ready` bit is set, `res_valid` is 0 and `ins_ready` is 1.
- R2: A cycle with `sel_we` high loads `sel_wdata` into the selector, and `sel_rdata` shows it from the next cycle on. An instruction uses the selector value held when the instruction is accepted, so a write made while that instruction is in flight does not affect it.
- R3: An instruction is a custom function only when `ins_word[6:0]` is 7'b0001011 or 7'b0101011. Any other accepted instruction is dropped: it raises no request and no result, and leaves `cf_status` unchanged.
- R4: A custom instruction raises `u_req_valid` only on bit `sel[7:0]`. The payload carries `u_req_ctx` = `sel[15:8]`, `u_req_func` = {`ins_word[31:25]`, `ins_word[14:12]`}, `u_req_a` = `ins_rs1` and `u_req_b` = `ins_rs2`. The request appears in the cycle after acceptance.
- R5: While a request is valid and not ready, the valid bit and the whole payload stay unchanged.
- R6: After the request handshake, `u_rsp_ready` is set only on the selected unit. Response valids from other units are ignored.
- R7: From acceptance until the result handshake, `ins_ready` is 0, so at most one transaction is in flight.
- R8: A unit index of `NUNITS` or more contacts no unit. In the cycle after acceptance, it yields a result of 0 with status 4.
- R9: The result is offered in the cycle after the response handshake. `res_status` is the unit's 2-bit code (0 success, 1..3 unit error), zero-extended to 3 bits. `cf_status` takes `res_status` on the result handshake and keeps it until the next custom instruction completes.
- R10: While `res_valid` is high and `res_ready` is low, `res_valid`, `res_data` and `res_status` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_we | input | 1 | Selector write strobe |
| sel_wdata | input | 32 | Selector write value (unit in [7:0], context in [15:8]) |
| sel_rdata | output | 32 | Current selector value |
| ins_valid | input | 1 | Decoded instruction offered |
| ins_ready | output | 1 | Dispatcher idle and accepting |
| ins_word | input | 32 | Instruction word |
| ins_rs1 | input | XLEN | First source operand |
| ins_rs2 | input | XLEN | Second source operand |
| res_valid | output | 1 | Destination result offered |
| res_ready | input | 1 | Core takes the result |
| res_data | output | XLEN | Destination-register value |
| res_status | output | USTW+1 | Status code of this result |
| cf_status | output | USTW+1 | Custom-function status register |
| u_req_valid | output | NUNITS | Per-unit request valid |
| u_req_ready | input | NUNITS | Per-unit request ready |
| u_req_ctx | output | CTXW | State context index |
| u_req_func | output | 10 | Function code |
| u_req_a | output | XLEN | Operand A |
| u_req_b | output | XLEN | Operand B |
| u_rsp_valid | input | NUNITS | Per-unit response valid |
| u_rsp_ready | output | NUNITS | Per-unit response ready |
| u_rsp_data | input | NUNITS*XLEN | Per-unit response values, unit i at slice i |
| u_rsp_status | input | NUNITS*USTW | Per-unit response codes, unit i at slice i |

## Verification
A wrong latched unit index shows one cycle after acceptance: the request valid appears on the wrong bit, or appears for an index that is out of range. A stale context, function or operand register shows in the payload in that same cycle. A faulty state register shows as `ins_ready` reopening early, as a request raised a second time, or as a result that never arrives; each of these is visible within a cycle of the handshake that follows. A status register that is written at the wrong moment shows on `cf_status` in the cycle after the result handshake, or after a dropped non-custom instruction.

// File: rtl/cfu_dispatch.sv
module cfu_dispatch #(
  parameter int NUNITS = 3,
  parameter int XLEN   = 32,
  parameter int CTXW   = 8,
  parameter int USTW   = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sel_we,
  input  logic [31:0]              sel_wdata,
  output logic [31:0]              sel_rdata,
  input  logic                     ins_valid,
  output logic                     ins_ready,
  input  logic [31:0]              ins_word,
  input  logic [XLEN-1:0]          ins_rs1,
  input  logic [XLEN-1:0]          ins_rs2,
  output logic                     res_valid,
  input  logic                     res_ready,
  output logic [XLEN-1:0]          res_data,
  output logic [USTW:0]            res_status,
  output logic [USTW:0]            cf_status,
  output logic [NUNITS-1:0]        u_req_valid,
  input  logic [NUNITS-1:0]        u_req_ready,
  output logic [CTXW-1:0]          u_req_ctx,
  output logic [9:0]               u_req_func,
  output logic [XLEN-1:0]          u_req_a,
  output logic [XLEN-1:0]          u_req_b,
  input  logic [NUNITS-1:0]        u_rsp_valid,
  output logic [NUNITS-1:0]        u_rsp_ready,
  input  logic [NUNITS*XLEN-1:0]   u_rsp_data,
  input  logic [NUNITS*USTW-1:0]   u_rsp_status
);
  localparam int UIDW = 8;
  localparam int STW  = USTW + 1;
  localparam logic [STW-1:0] BADSEL = STW'(1) << USTW;
  localparam logic [6:0] OPC_C0 = 7'b0001011;
  localparam logic [6:0] OPC_C1 = 7'b0101011;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_RSP, S_DONE} st_t;

  st_t             st;
  logic [31:0]     sel_q;
  logic [UIDW-1:0] unit_q;
  logic [CTXW-1:0] ctx_q;
  logic [9:0]      func_q;
  logic [XLEN-1:0] a_q, b_q, rd_q;
  logic [STW-1:0]  rs_q, stat_q;

  logic            is_custom, accept, in_range;
  logic            pick_valid;
  logic [XLEN-1:0] pick_data;
  logic [USTW-1:0] pick_stat;

  assign is_custom = (ins_word[6:0] == OPC_C0) || (ins_word[6:0] == OPC_C1);
  assign ins_ready = (st == S_IDLE);
  assign accept    = ins_valid && ins_ready;
  assign in_range  = sel_q[UIDW-1:0] < UIDW'(NUNITS);

  assign sel_rdata  = sel_q;
  assign res_valid  = (st == S_DONE);
  assign res_data   = rd_q;
  assign res_status = rs_q;
  assign cf_status  = stat_q;
  assign u_req_ctx  = ctx_q;
  assign u_req_func = func_q;
  assign u_req_a    = a_q;
  assign u_req_b    = b_q;

  for (genvar i = 0; i < NUNITS; i++) begin : g_route
    assign u_req_valid[i] = (st == S_REQ) && (unit_q == UIDW'(i));
    assign u_rsp_ready[i] = (st == S_RSP) && (unit_q == UIDW'(i));
  end

  always_comb begin
    pick_valid = 1'b0;
    pick_data  = '0;
    pick_stat  = '0;
    for (int i = 0; i < NUNITS; i++) begin
      if (unit_q == UIDW'(i)) begin
        pick_valid = u_rsp_valid[i];
        pick_data  = u_rsp_data[i*XLEN +: XLEN];
        pick_stat  = u_rsp_status[i*USTW +: USTW];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= '0;
    end else if (sel_we) begin
      sel_q <= sel_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      unit_q <= '0;
      ctx_q  <= '0;
      func_q <= '0;
      a_q    <= '0;
      b_q    <= '0;
      rd_q   <= '0;
      rs_q   <= '0;
      stat_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (accept && is_custom) begin
          unit_q <= sel_q[UIDW-1:0];
          ctx_q  <= sel_q[UIDW +: CTXW];
          func_q <= {ins_word[31:25], ins_word[14:12]};
          a_q    <= ins_rs1;
          b_q    <= ins_rs2;
          if (in_range) begin
            st <= S_REQ;
          end else begin
            rd_q <= '0;
            rs_q <= BADSEL;
            st   <= S_DONE;
          end
        end
        S_REQ: if (|(u_req_valid & u_req_ready)) st <= S_RSP;
        S_RSP: if (pick_valid) begin
          rd_q <= pick_data;
          rs_q <= {1'b0, pick_stat};
          st   <= S_DONE;
        end
        S_DONE: if (res_ready) begin
          stat_q <= rs_q;
          st     <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cfu_dispatch_chk.sv
module cfu_dispatch_chk #(
  parameter int NUNITS = 3,
  parameter int XLEN   = 32,
  parameter int CTXW   = 8,
  parameter int USTW   = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ins_ready,
  input logic              res_valid,
  input logic              res_ready,
  input logic [XLEN-1:0]   res_data,
  input logic [USTW:0]     res_status,
  input logic [NUNITS-1:0] u_req_valid,
  input logic [NUNITS-1:0] u_req_ready,
  input logic [CTXW-1:0]   u_req_ctx,
  input logic [9:0]        u_req_func,
  input logic [XLEN-1:0]   u_req_a,
  input logic [XLEN-1:0]   u_req_b,
  input logic [NUNITS-1:0] u_rsp_ready
);
  localparam logic [USTW:0] BAD = (USTW+1)'(1) << USTW;

  AST_REQ_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(u_req_valid)); // R4
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (|(u_req_valid & ~u_req_ready)) |=> $stable(u_req_valid) && $stable(u_req_ctx)
      && $stable(u_req_func) && $stable(u_req_a) && $stable(u_req_b)); // R5
  AST_RSP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(u_rsp_ready)); // R6
  AST_SINGLE_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    ((|u_req_valid) || (|u_rsp_ready)) |-> !ins_ready && !res_valid); // R7
  AST_BADSEL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_status == BAD) |-> res_data == '0); // R8
  AST_RES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> res_valid && $stable(res_data) && $stable(res_status)); // R10
endmodule

bind cfu_dispatch cfu_dispatch_chk #(.NUNITS(NUNITS), .XLEN(XLEN), .CTXW(CTXW), .USTW(USTW)) i_chk (
  .clk(clk), .rst_n(rst_n), .ins_ready(ins_ready), .res_valid(res_valid),
  .res_ready(res_ready), .res_data(res_data), .res_status(res_status),
  .u_req_valid(u_req_valid), .u_req_ready(u_req_ready), .u_req_ctx(u_req_ctx),
  .u_req_func(u_req_func), .u_req_a(u_req_a), .u_req_b(u_req_b),
  .u_rsp_ready(u_rsp_ready)
);

// File: tb/test_cfu_dispatch.sv
module test_cfu_dispatch;
  localparam int CLK_PERIOD = 10;
  localparam int N = 3;
  localparam int XL = 32;

  logic clk = 0, rst_n = 0;
  logic sel_we = 0; logic [31:0] sel_wdata = 0; logic [31:0] sel_rdata;
  logic ins_valid = 0, ins_ready; logic [31:0] ins_word = 0;
  logic [XL-1:0] ins_rs1 = 0, ins_rs2 = 0;
  logic res_valid, res_ready = 0; logic [XL-1:0] res_data;
  logic [2:0] res_status, cf_status;
  logic [N-1:0] u_req_valid, u_req_ready = 0, u_rsp_valid = 0, u_rsp_ready;
  logic [7:0] u_req_ctx; logic [9:0] u_req_func; logic [XL-1:0] u_req_a, u_req_b;
  logic [N*XL-1:0] u_rsp_data = 0; logic [N*2-1:0] u_rsp_status = 0;

  int checks = 0, errors = 0;
  logic [31:0] sel_m = 0;
  logic [2:0] stat_m = 0;

  cfu_dispatch #(.NUNITS(N), .XLEN(XL), .CTXW(8), .USTW(2)) i_cfu_dispatch (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic write_sel(input logic [31:0] v);
    @(negedge clk); sel_we = 1; sel_wdata = v;
    @(negedge clk); sel_we = 0; sel_m = v;
    chk(sel_rdata == v, "R2 selector readback", sel_rdata, v);
  endtask

  function automatic logic [XL-1:0] unit_val(int u, logic [XL-1:0] a, logic [XL-1:0] b, logic [9:0] f);
    return (a ^ (b + XL'(u * 7))) + XL'(f);
  endfunction

  task automatic do_op(input logic [31:0] w, input logic [XL-1:0] a, input logic [XL-1:0] b,
                       input int rqd, input int rsd, input int rrd, input logic [1:0] ust,
                       input logic [31:0] late_sel, input bit do_late);
    logic [6:0] op = w[6:0];
    bit cust = (op == 7'b0001011) || (op == 7'b0101011);
    int u = int'(sel_m[7:0]);
    logic [7:0] cx = sel_m[15:8];
    logic [9:0] f = {w[31:25], w[14:12]};
    logic [XL-1:0] ev;
    logic [2:0] es;
    @(negedge clk);
    chk(ins_ready == 1, "R7 idle ready", ins_ready, 1);
    ins_valid = 1; ins_word = w; ins_rs1 = a; ins_rs2 = b;
    @(negedge clk); ins_valid = 0;
    if (!cust) begin
      chk(u_req_valid == 0 && res_valid == 0, "R3 dropped no activity", {u_req_valid, res_valid}, 0);
      @(negedge clk);
      chk(cf_status == stat_m && ins_ready, "R3 status kept", cf_status, stat_m);
      return;
    end
    chk(ins_ready == 0, "R7 busy after accept", ins_ready, 0);
    if (u >= N) begin
      chk(u_req_valid == 0, "R8 no unit contacted", u_req_valid, 0);
      ev = 0; es = 3'd4;
    end else begin
      chk(u_req_valid == N'(1 << u), "R4 request target", u_req_valid, 1 << u);
      chk(u_req_ctx == cx && u_req_func == f && u_req_a == a && u_req_b == b,
          "R4 payload", {u_req_ctx, u_req_func}, {cx, f});
      for (int k = 0; k < rqd; k++) begin
        @(negedge clk);
        chk(u_req_valid == N'(1 << u) && u_req_a == a && u_req_func == f,
            "R5 request held", u_req_valid, 1 << u);
      end
      if (do_late) begin sel_we = 1; sel_wdata = late_sel; end
      u_req_ready = N'(1 << u);
      @(negedge clk); u_req_ready = 0; sel_we = 0;
      if (do_late) sel_m = late_sel;
      chk(u_req_valid == 0 && u_rsp_ready == N'(1 << u), "R6 response ready target", u_rsp_ready, 1 << u);
      chk(ins_ready == 0 && res_valid == 0, "R7 busy waiting response", ins_ready, 0);
      ev = unit_val(u, a, b, f); es = {1'b0, ust};
      u_rsp_valid = ~N'(1 << u);
      for (int j = 0; j < N; j++) begin
        u_rsp_data[j*XL +: XL] = (j == u) ? ev : ~ev;
        u_rsp_status[j*2 +: 2] = (j == u) ? ust : ~ust;
      end
      for (int k = 0; k < rsd; k++) begin
        @(negedge clk);
        chk(res_valid == 0 && u_rsp_ready == N'(1 << u), "R6 other units ignored", res_valid, 0);
      end
      u_rsp_valid = N'(1 << u) | u_rsp_valid;
      @(negedge clk); u_rsp_valid = 0;
    end
    chk(res_valid == 1, "R9 result offered", res_valid, 1);
    chk(res_data == ev, "R9 result data", res_data, ev);
    chk(res_status == es, "R9 result status", res_status, es);
    for (int k = 0; k < rrd; k++) begin
      @(negedge clk);
      chk(res_valid && res_data == ev && res_status == es && ins_ready == 0, "R10 result held", res_data, ev);
      chk(cf_status == stat_m, "R9 status not yet updated", cf_status, stat_m);
    end
    res_ready = 1;
    @(negedge clk); res_ready = 0;
    stat_m = es;
    chk(cf_status == es && res_valid == 0 && ins_ready == 1, "R9 status register", cf_status, es);
    if (do_late) chk(sel_rdata == late_sel, "R2 late write visible", sel_rdata, late_sel);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(sel_rdata == 0 && cf_status == 0 && u_req_valid == 0 && u_rsp_ready == 0
        && res_valid == 0 && ins_ready == 1, "R1 reset state", {sel_rdata, cf_status}, 0);
    for (int u = 0; u < 5; u++) begin
      for (int cx = 0; cx < 3; cx++) begin
        write_sel({16'hA5A5, 8'(cx * 37 + 1), 8'(u)});
        for (int o = 0; o < 2; o++) begin
          for (int f3 = 0; f3 < 8; f3 += 3) begin
            logic [31:0] w = {7'(u * 11 + f3 + cx), 5'd3, 5'd4, 3'(f3), 5'd9,
                              (o == 0) ? 7'b0001011 : 7'b0101011};
            do_op(w, 32'h1234_0000 + 32'(u * 100 + f3), 32'hF0F0_0001 * 32'(cx + o + 1),
                  (f3 + cx) % 3, (u + f3) % 3, (cx + o) % 3, 2'((f3 + u) % 4), 0, 0);
          end
        end
      end
    end
    write_sel(32'h0000_11FF);
    do_op({7'h7F, 10'd0, 3'd7, 5'd1, 7'b0001011}, 32'h5, 32'h6, 0, 0, 1, 0, 0, 0);
    write_sel(32'h0000_2201);
    do_op({7'h01, 10'd0, 3'd2, 5'd1, 7'b0101011}, 32'hABCD, 32'h1, 1, 1, 0, 2'd0, 0, 0);
    do_op({7'h01, 10'd0, 3'd2, 5'd1, 7'b0110011}, 32'h1, 32'h2, 0, 0, 0, 0, 0, 0);
    do_op({7'h00, 10'd0, 3'd0, 5'd1, 7'b0001111}, 32'h1, 32'h2, 0, 0, 0, 0, 0, 0);
    do_op({7'h12, 10'd0, 3'd5, 5'd1, 7'b0001011}, 32'h77, 32'h88, 1, 2, 1, 2'd3, 32'h0000_3302, 1);
    do_op({7'h13, 10'd0, 3'd4, 5'd1, 7'b0101011}, 32'h99, 32'h11, 0, 0, 0, 2'd1, 0, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule